// File: doc/BRIEF.md
# Exception Admission Gate

This block decides, one cycle at a time, whether a single pending exception may be taken. Three software-visible mask registers feed the decision. The first is a global disable bit, which leaves only the non-maskable interrupt and the hard fault class able to pass. The second is a fault disable bit, which leaves only the non-maskable interrupt able to pass. The third is a priority threshold: when it is non-zero, any fault or interrupt whose priority number is at least the threshold is held back. A larger priority number means a less urgent exception.

The decision is purely combinational from the stored mask values and the current request, so the exception entry logic can use it in the same cycle. The masks are written through a small register port. Each write carries a privilege qualifier, and a write made at user level is dropped. The stored values can be read back at any time. Arbitration between several pending exceptions, vector fetch and stacking belong to other blocks.

Top module: `exc_admit_gate`

## Requirements
- R1: After reset all three read-back ports are zero and no exception class is masked.
- R2: A pending exception of class 0 (non-maskable interrupt) is always allowed, whatever the mask values and priority.
- R3: With the global disable bit set (read-back bit 0 of `rd_glob`) and the fault disable bit clear, class 1 (hard fault) is allowed, and classes 2 (other fault) and 3 (interrupt) are blocked.
- R4: With the fault disable bit set (read-back bit 0 of `rd_flt`), classes 1, 2 and 3 are blocked and class 0 is allowed.
- R5: With a non-zero threshold, a class 2 or class 3 exception whose priority is greater than or equal to the threshold is blocked, and one whose priority is below it is allowed (when neither disable bit is set).
- R6: A threshold of zero masks nothing.
- R7: The threshold has no effect on classes 0 and 1.
- R8: A write with `wr_priv` low changes none of the three mask registers.
- R9: A privileged write selects a register by `wr_sel` (0 global disable, taking `wr_data[0]`; 1 fault disable, taking `wr_data[0]`; 2 threshold, taking all of `wr_data`; 3 no register). The new value appears on the read-back port and in the decision on the first clock edge after the write, and not before. Read-back bits above the stored width are zero.
- R10: `take_ok` is low whenever `pend_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pend_vld | input | 1 | A pending exception is presented |
| pend_cls | input | 2 | Exception class: 0 non-maskable interrupt, 1 hard fault, 2 other fault, 3 interrupt |
| pend_prio | input | PRIO_W | Priority number of the pending exception; larger means less urgent |
| wr_en | input | 1 | Mask register write strobe |
| wr_sel | input | 2 | Write target: 0 global disable, 1 fault disable, 2 threshold, 3 none |
| wr_data | input | PRIO_W | Write data |
| wr_priv | input | 1 | High when the writer runs at privileged level |
| take_ok | output | 1 | The pending exception may be taken |
| rd_glob | output | DATA_W | Global disable read-back, bit 0 |
| rd_flt | output | DATA_W | Fault disable read-back, bit 0 |
| rd_thr | output | DATA_W | Threshold read-back, low PRIO_W bits |

## Verification
The bench sweeps every class against every priority value under every pair of disable bits and a set of thresholds that includes 0, 1, 255 and values next to powers of two. This catches a comparison that uses greater-than instead of greater-or-equal, which would let an exception whose priority equals the threshold through. It also catches a zero threshold that masks everything, and a global disable that wrongly blocks the hard fault class. Separate cases write each register at user level and confirm that nothing moves. They also look at the read-back just before and just after the write edge, which exposes a write that lands a cycle early or late. Writes with all upper data bits set check that the single-bit registers read back as exactly 1.

// File: rtl/exc_admit_pkg.sv
package exc_admit_pkg;

  typedef enum logic [1:0] {
    CLS_NMI   = 2'd0,
    CLS_HARDF = 2'd1,
    CLS_FAULT = 2'd2,
    CLS_IRQ   = 2'd3
  } exc_cls_e;

  typedef enum logic [1:0] {
    SEL_GLOB = 2'd0,
    SEL_FLT  = 2'd1,
    SEL_THR  = 2'd2,
    SEL_NONE = 2'd3
  } mask_sel_e;

endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/exc_mask_regs.sv
module exc_mask_regs
  import exc_admit_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [PRIO_W-1:0] wr_data,
  input  logic              wr_priv,
  output logic              glob_q,
  output logic              flt_q,
  output logic [PRIO_W-1:0] thr_q
);
  logic              wr_ok;
  logic              glob_en, flt_en, thr_en;
  logic              glob_d, flt_d;
  logic [PRIO_W-1:0] thr_d;

  // Only a privileged writer may update a mask.
  assign wr_ok = wr_en & wr_priv;

  always_comb begin
    glob_en = wr_ok && (mask_sel_e'(wr_sel) == SEL_GLOB);
    flt_en  = wr_ok && (mask_sel_e'(wr_sel) == SEL_FLT);
    thr_en  = wr_ok && (mask_sel_e'(wr_sel) == SEL_THR);
    glob_d  = wr_data[0];
    flt_d   = wr_data[0];
    thr_d   = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= 1'b0;
      flt_q  <= 1'b0;
      thr_q  <= '0;
    end else begin
      if (glob_en) glob_q <= glob_d;
      if (flt_en)  flt_q  <= flt_d;
      if (thr_en)  thr_q  <= thr_d;
    end
  end
endmodule

// File: rtl/exc_thr_cmp.sv
module exc_thr_cmp #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] thr,
  input  logic [PRIO_W-1:0] prio,
  output logic              hit
);
  logic thr_active;

  // Zero threshold disables the compare; equal priority counts as masked.
  assign thr_active = |thr;
  assign hit        = thr_active && (prio >= thr);
endmodule

// File: rtl/exc_admit_decide.sv
module exc_admit_decide
  import exc_admit_pkg::*;
(
  input  logic       vld,
  input  logic [1:0] cls,
  input  logic       glob,
  input  logic       flt,
  input  logic       thr_hit,
  output logic       ok
);
  logic allow;

  always_comb begin
    unique case (exc_cls_e'(cls))
      CLS_NMI:   allow = 1'b1;
      CLS_HARDF: allow = !flt;
      default:   allow = !flt && !glob && !thr_hit;
    endcase
  end

  assign ok = vld && allow;
endmodule

// File: rtl/exc_admit_gate.sv
module exc_admit_gate
  import exc_admit_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_vld,
  input  logic [1:0]        pend_cls,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [PRIO_W-1:0] wr_data,
  input  logic              wr_priv,
  output logic              take_ok,
  output logic [DATA_W-1:0] rd_glob,
  output logic [DATA_W-1:0] rd_flt,
  output logic [DATA_W-1:0] rd_thr
);
  localparam int PAD_W = DATA_W - PRIO_W;

  logic              rst_n_sync;
  logic              glob_q, flt_q, thr_hit;
  logic [PRIO_W-1:0] thr_q;

  exc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  exc_mask_regs #(.PRIO_W(PRIO_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .wr_priv (wr_priv),
    .glob_q  (glob_q),
    .flt_q   (flt_q),
    .thr_q   (thr_q)
  );

  exc_thr_cmp #(.PRIO_W(PRIO_W)) u_cmp (
    .thr  (thr_q),
    .prio (pend_prio),
    .hit  (thr_hit)
  );

  exc_admit_decide u_dec (
    .vld     (pend_vld),
    .cls     (pend_cls),
    .glob    (glob_q),
    .flt     (flt_q),
    .thr_hit (thr_hit),
    .ok      (take_ok)
  );

  assign rd_glob = {{(DATA_W-1){1'b0}}, glob_q};
  assign rd_flt  = {{(DATA_W-1){1'b0}}, flt_q};

  generate
    if (PAD_W > 0) begin : g_thr_pad
      assign rd_thr = {{PAD_W{1'b0}}, thr_q};
    end else begin : g_thr_full
      assign rd_thr = thr_q;
    end
  endgenerate
endmodule

// File: rtl/exc_admit_gate_chk.sv
module exc_admit_gate_chk
  import exc_admit_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pend_vld,
  input logic [1:0]        pend_cls,
  input logic [PRIO_W-1:0] pend_prio,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [PRIO_W-1:0] wr_data,
  input logic              wr_priv,
  input logic              take_ok,
  input logic [DATA_W-1:0] rd_glob,
  input logic [DATA_W-1:0] rd_flt,
  input logic [DATA_W-1:0] rd_thr
);
  p_nmi_always_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && pend_cls == CLS_NMI) |-> take_ok);

  p_glob_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_glob[0] && pend_vld && pend_cls[1]) |-> !take_ok);

  p_glob_spares_hard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_glob[0] && !rd_flt[0] && pend_vld && pend_cls == CLS_HARDF) |-> take_ok);

  p_flt_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flt[0] && pend_vld && pend_cls != CLS_NMI) |-> !take_ok);

  p_thr_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_thr != '0) && pend_vld && pend_cls[1] &&
     ({{(DATA_W-PRIO_W){1'b0}}, pend_prio} >= rd_thr)) |-> !take_ok);

  p_user_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_priv) |=> ($stable(rd_glob) && $stable(rd_flt) && $stable(rd_thr)));

  p_thr_wr_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_priv && wr_sel == SEL_THR) |=>
      (rd_thr == {{(DATA_W-PRIO_W){1'b0}}, $past(wr_data)}));

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_glob[DATA_W-1:1] == '0) && (rd_flt[DATA_W-1:1] == '0));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_vld |-> !take_ok);
endmodule

bind exc_admit_gate exc_admit_gate_chk #(.PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .pend_vld  (pend_vld),
  .pend_cls  (pend_cls),
  .pend_prio (pend_prio),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .wr_priv   (wr_priv),
  .take_ok   (take_ok),
  .rd_glob   (rd_glob),
  .rd_flt    (rd_flt),
  .rd_thr    (rd_thr)
);

// File: tb/test_exc_admit_gate.sv
module test_exc_admit_gate;
  localparam int CLK_PERIOD = 10;
  localparam int PRIO_W     = 8;
  localparam int DATA_W     = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              pend_vld;
  logic [1:0]        pend_cls;
  logic [PRIO_W-1:0] pend_prio;
  logic              wr_en;
  logic [1:0]        wr_sel;
  logic [PRIO_W-1:0] wr_data;
  logic              wr_priv;
  logic              take_ok;
  logic [DATA_W-1:0] rd_glob, rd_flt, rd_thr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_admit_gate #(.PRIO_W(PRIO_W), .DATA_W(DATA_W)) i_exc_admit_gate (
    .clk(clk), .rst_n(rst_n), .pend_vld(pend_vld), .pend_cls(pend_cls),
    .pend_prio(pend_prio), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wr_priv(wr_priv), .take_ok(take_ok), .rd_glob(rd_glob), .rd_flt(rd_flt),
    .rd_thr(rd_thr)
  );

  function automatic bit exp_ok(bit v, int cls, bit g, bit f, int thr, int pr);
    if (!v) return 1'b0;
    case (cls)
      0:       return 1'b1;
      1:       return !f;
      default: return !f && !g && !((thr != 0) && (pr >= thr));
    endcase
  endfunction

  task automatic check_val(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_reg(int sel, int data, bit priv);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_sel  = 2'(sel);
    wr_data = PRIO_W'(data);
    wr_priv = priv;
    @(posedge clk);
    #1;
    wr_en   = 1'b0;
    wr_priv = 1'b1;
  endtask

  task automatic sweep(bit g, bit f, int thr);
    write_reg(0, g ? 8'hFF : 8'h00, 1'b1);
    write_reg(1, f ? 8'hFE | 8'h01 : 8'h00, 1'b1);
    write_reg(2, thr, 1'b1);
    check_val("R9 glob readback", rd_glob, g);
    check_val("R9 flt readback", rd_flt, f);
    check_val("R9 thr readback", rd_thr, thr);
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 256; p++) begin
        string tag;
        pend_vld  = 1'b1;
        pend_cls  = 2'(c);
        pend_prio = 8'(p);
        #1;
        if (c == 0)      tag = "R2";
        else if (c == 1) tag = f ? "R4" : "R7";
        else if (f)      tag = "R4";
        else if (g)      tag = "R3";
        else if (thr == 0) tag = "R6";
        else             tag = "R5";
        check_val($sformatf("%s cls=%0d prio=%0d g=%0d f=%0d thr=%0d", tag, c, p, g, f, thr),
                  take_ok, exp_ok(1'b1, c, g, f, thr, p));
      end
    end
    pend_vld = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int thr_set [10] = '{0, 1, 2, 3, 64, 127, 128, 200, 254, 255};
    rst_n = 1'b0; pend_vld = 1'b0; pend_cls = 2'd0; pend_prio = '0;
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0; wr_priv = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1: reset state
    check_val("R1 glob reset", rd_glob, 0);
    check_val("R1 flt reset", rd_flt, 0);
    check_val("R1 thr reset", rd_thr, 0);
    pend_vld = 1'b1; pend_cls = 2'd3; pend_prio = 8'hFF; #1;
    check_val("R1 irq allowed after reset", take_ok, 1);

    // R10: idle request
    pend_vld = 1'b0; #1;
    check_val("R10 no request", take_ok, 0);

    // R8: user-level writes dropped
    write_reg(0, 8'hFF, 1'b0);
    check_val("R8 glob user write", rd_glob, 0);
    write_reg(1, 8'hFF, 1'b0);
    check_val("R8 flt user write", rd_flt, 0);
    write_reg(2, 8'h40, 1'b0);
    check_val("R8 thr user write", rd_thr, 0);
    pend_vld = 1'b1; pend_cls = 2'd2; pend_prio = 8'h80; #1;
    check_val("R8 decision unchanged", take_ok, 1);
    pend_vld = 1'b0;

    // R9: timing of a privileged write, select 3 writes nothing
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h21; wr_priv = 1'b1;
    #1;
    check_val("R9 thr before edge", rd_thr, 0);
    @(posedge clk); #1;
    wr_en = 1'b0;
    check_val("R9 thr after edge", rd_thr, 32'h21);
    write_reg(3, 8'hFF, 1'b1);
    check_val("R9 sel none glob", rd_glob, 0);
    check_val("R9 sel none flt", rd_flt, 0);
    check_val("R9 sel none thr", rd_thr, 32'h21);
    write_reg(1, 8'hFF, 1'b1);
    check_val("R9 flt upper bits zero", rd_flt, 1);
    write_reg(1, 8'h00, 1'b1);

    // R2..R7: sweeps
    for (int m = 0; m < 4; m++) begin
      for (int t = 0; t < 10; t++) begin
        sweep(m[0], m[1], thr_set[t]);
      end
    end

    // R10 once more with masks clear
    write_reg(0, 0, 1'b1); write_reg(1, 0, 1'b1); write_reg(2, 0, 1'b1);
    pend_vld = 1'b0; pend_cls = 2'd0; #1;
    check_val("R10 idle nmi", take_ok, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule